// File: doc/BRIEF.md
# Ternary Match Table with Staged Result Commit

This block is a small ternary match table. Each of its lines holds a wide key value, a care mask of the same width, a multi-word result and a valid flag. A host programs and reads every line through one word-wide register port. That port carries a space select, a line index and a slot number within the line. Key and mask words share one slot space. Result words live in a second space.

Every cycle the block can take a lookup key and compare it with all valid lines at once. One cycle later it reports whether any line hit, the index of the lowest hitting line, and that line's committed result. The block does not change a line's result word by word. It collects result writes in a shadow buffer and commits them into the line only when the final result word is written. That write also makes the line valid, so a lookup never sees a half-programmed result.

Top module: `tmt_table`

## Requirements
- R1: In the key/mask space (`host_sel_res`=0), slot 2*i holds key word i and slot 2*i+1 holds mask word i, for full words i = 0..5. Key word i occupies key bits 32*i+31:32*i. A read returns the last value written.
- R2: Slot 12 (0xC) holds the 16-bit top parts of key and mask together. Bits 15:0 carry key bits 207:192 and bits 31:16 carry mask bits 207:192. A read returns the two parts packed in the same way.
- R3: A valid line hits when every key bit whose mask bit is 1 equals the stored key bit. Key bits whose mask bit is 0 are ignored.
- R4: A write of a value with bit 0 set to slot 13 (0xD) makes the line invalid. A write with bit 0 clear has no effect. A read of slot 13 returns 1 in bit 0 when the line is invalid. Invalidation leaves the key, mask and result contents readable and unchanged.
- R5: In the result space (`host_sel_res`=1), slot w holds result word w, for w = 0..3. A write to slot 3 commits the result into the line and makes the line valid. A line whose result has never been committed never hits.
- R6: A write to result slots 0..2 only stages the word. Lookups and result reads see the previously committed words until the commit. At commit, result words that were not staged keep their old values.
- R7: When several valid lines hit, the lowest line index wins.
- R8: A lookup presented with `lk_valid` produces a single-cycle `hit_valid` pulse on the next cycle. `hit_valid` stays low in all other cycles. With no hit, `hit_index` and `hit_result` read 0.
- R9: After reset, every line is invalid, all stored words read 0, and no lookup hits.
- R10: Key bits 207:204 form the section field and bits 203:200 form the port field. A line whose mask clears only the section bits hits for every section value, but only for its own port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe; data appears on the next cycle |
| host_sel_res | input | 1 | 0 selects the key/mask space, 1 selects the result space |
| host_line | input | 3 | Line index |
| host_slot | input | 4 | Slot within the line |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 208 | Lookup key |
| hit_valid | output | 1 | Lookup answer valid |
| hit | output | 1 | At least one valid line hit |
| hit_index | output | 3 | Lowest hitting line |
| hit_result | output | 128 | Committed result of that line, word 0 in the low bits |

## Verification
A wrong valid flag or a corrupted key or mask bit shows on the very next lookup's answer. It appears as a missing hit, a hit on the wrong line or a hit that should not happen, and it can also be read through slot 13 or the key slots one cycle after the read strobe. A shadow buffer that leaks into the table is caught by a lookup or result read placed between a staged word and its commit. A shadow that fails to merge shows in the first lookup after the commit. A priority fault needs two overlapping valid lines to become visible, so the stimulus deliberately creates such overlaps.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

  localparam int WORD_W = 32;
  localparam int TOP_W  = 16;

  typedef enum logic [2:0] {
    SK_KEY,
    SK_MASK,
    SK_TOP,
    SK_INV,
    SK_NONE
  } slot_kind_e;

  // classify a key/mask-space slot for a table with 'full' whole key words
  function automatic slot_kind_e slot_kind(input int unsigned slot, input int unsigned full);
    if (slot < 2 * full) return (slot % 2 == 0) ? SK_KEY : SK_MASK;
    if (slot == 2 * full) return SK_TOP;
    if (slot == 2 * full + 1) return SK_INV;
    return SK_NONE;
  endfunction

  // which whole key word a key or mask slot addresses
  function automatic int unsigned word_of(input int unsigned slot);
    return slot / 2;
  endfunction

  // ternary compare: bits under a set mask bit must agree
  function automatic logic tern_eq(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                                   input logic [WORD_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

endpackage

// File: rtl/tmt_array.sv
module tmt_array
  import tmt_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int FULL_WORDS = 6,
  parameter int LW         = 3,
  parameter int SW         = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [LW-1:0]        line,
  input  logic [SW-1:0]        slot,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 set_valid,
  input  logic [LW-1:0]        set_line,
  input  logic [32*FULL_WORDS+TOP_W-1:0] lk_key,
  output logic [LINES-1:0]     match_vec,
  output logic [WORD_W-1:0]    rd_word
);
  localparam int KEY_W  = WORD_W * FULL_WORDS + TOP_W;
  localparam int WORDS  = FULL_WORDS + 1;
  localparam int PAD_W  = WORD_W * WORDS;

  logic [KEY_W-1:0] kv [LINES];
  logic [KEY_W-1:0] km [LINES];
  logic [LINES-1:0] valid;

  slot_kind_e  kind;
  int unsigned widx;
  assign kind = slot_kind(int'(slot), FULL_WORDS);
  assign widx = word_of(int'(slot));

  // named internal event for the checks
  logic inv_evt;
  assign inv_evt = we && (kind == SK_INV) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        kv[l] <= '0;
        km[l] <= '0;
      end
      valid <= '0;
    end else begin
      if (we) begin
        case (kind)
          SK_KEY:  kv[line][widx*WORD_W +: WORD_W] <= wdata;
          SK_MASK: km[line][widx*WORD_W +: WORD_W] <= wdata;
          SK_TOP: begin
            kv[line][KEY_W-1 -: TOP_W] <= wdata[TOP_W-1:0];
            km[line][KEY_W-1 -: TOP_W] <= wdata[WORD_W-1 -: TOP_W];
          end
          SK_INV:  if (wdata[0]) valid[line] <= 1'b0;
          default: ;
        endcase
      end
      if (set_valid) valid[set_line] <= 1'b1;
    end
  end

  // parallel ternary compare, one word slice at a time
  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [PAD_W-1:0] k_p, v_p, m_p;
      logic [WORDS-1:0] w_ok;
      assign k_p = PAD_W'(lk_key);
      assign v_p = PAD_W'(kv[l]);
      assign m_p = PAD_W'(km[l]);
      for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign w_ok[w] = tern_eq(k_p[w*WORD_W +: WORD_W], v_p[w*WORD_W +: WORD_W],
                                 m_p[w*WORD_W +: WORD_W]);
      end
      assign match_vec[l] = valid[l] && (&w_ok);
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    case (kind)
      SK_KEY:  rd_word = kv[line][widx*WORD_W +: WORD_W];
      SK_MASK: rd_word = km[line][widx*WORD_W +: WORD_W];
      SK_TOP:  rd_word = {km[line][KEY_W-1 -: TOP_W], kv[line][KEY_W-1 -: TOP_W]};
      SK_INV:  rd_word = {{(WORD_W-1){1'b0}}, ~valid[line]};
      default: rd_word = '0;
    endcase
  end

  // R4: invalidation takes effect on the next cycle
  a_r4_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt |=> !valid[$past(line)]);

  // R5: a commit leaves the line valid
  a_r5_commit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> valid[$past(set_line)]);

  // R4: invalidation never disturbs the stored key
  a_r4_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt |=> kv[$past(line)] == $past(kv[line]));

endmodule

// File: rtl/tmt_result.sv
module tmt_result #(
  parameter int LINES     = 8,
  parameter int RES_WORDS = 4,
  parameter int LW        = 3,
  parameter int SW        = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [LW-1:0]           line,
  input  logic [SW-1:0]           slot,
  input  logic [31:0]             wdata,
  input  logic [LW-1:0]           lk_line,
  output logic                    commit,
  output logic [31:0]             rd_word,
  output logic [32*RES_WORDS-1:0] lk_res
);
  localparam int RES_W = 32 * RES_WORDS;
  localparam int LAST  = RES_WORDS - 1;

  logic [RES_W-1:0]     mem [LINES];
  logic [RES_W-1:0]     shd;
  logic [RES_WORDS-1:0] shd_set;

  logic stage_evt;
  assign commit    = we && (int'(slot) == LAST);
  assign stage_evt = we && (int'(slot) < LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) mem[l] <= '0;
      shd     <= '0;
      shd_set <= '0;
    end else if (commit) begin
      for (int w = 0; w < LAST; w++)
        if (shd_set[w]) mem[line][w*32 +: 32] <= shd[w*32 +: 32];
      mem[line][LAST*32 +: 32] <= wdata;
      shd_set <= '0;
    end else if (stage_evt) begin
      shd[int'(slot)*32 +: 32] <= wdata;
      shd_set[int'(slot)]      <= 1'b1;
    end
  end

  assign rd_word = (int'(slot) < RES_WORDS) ? mem[line][int'(slot)*32 +: 32] : 32'h0;
  assign lk_res  = mem[lk_line];

  // R6: a staged word never reaches the committed table
  a_r6_staged_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    stage_evt |=> mem[$past(line)] == $past(mem[line]));

  // R5: the final word lands in the line at commit
  a_r5_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> mem[$past(line)][LAST*32 +: 32] == $past(wdata));

endmodule

// File: rtl/tmt_prio.sv
module tmt_prio #(
  parameter int LINES = 8,
  parameter int LW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] vec,
  output logic             any,
  output logic [LW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int l = LINES - 1; l >= 0; l--)
      if (vec[l]) idx = LW'(l);
  end
  assign any = |vec;

  // R7: the chosen line hits and no lower line does
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vec[idx] && ((vec & ((LINES'(1) << idx) - LINES'(1))) == '0)));

endmodule

// File: rtl/tmt_table.sv
module tmt_table #(
  parameter int LINES      = 8,
  parameter int FULL_WORDS = 6,
  parameter int RES_WORDS  = 4,
  parameter int LW         = $clog2(LINES),
  parameter int SW         = $clog2(2 * FULL_WORDS + 2),
  parameter int KEY_W      = 32 * FULL_WORDS + 16,
  parameter int RES_W      = 32 * RES_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic             host_sel_res,
  input  logic [LW-1:0]    host_line,
  input  logic [SW-1:0]    host_slot,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  output logic             hit_valid,
  output logic             hit,
  output logic [LW-1:0]    hit_index,
  output logic [RES_W-1:0] hit_result
);
  logic             arr_we, res_we, commit;
  logic [LINES-1:0] match_vec;
  logic [31:0]      arr_rd, res_rd;
  logic             any;
  logic [LW-1:0]    win;
  logic [RES_W-1:0] win_res;

  assign arr_we = host_we && !host_sel_res;
  assign res_we = host_we && host_sel_res;

  tmt_array #(.LINES(LINES), .FULL_WORDS(FULL_WORDS), .LW(LW), .SW(SW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .line(host_line), .slot(host_slot),
    .wdata(host_wdata), .set_valid(commit), .set_line(host_line), .lk_key(lk_key),
    .match_vec(match_vec), .rd_word(arr_rd)
  );

  tmt_result #(.LINES(LINES), .RES_WORDS(RES_WORDS), .LW(LW), .SW(SW)) u_result (
    .clk(clk), .rst_n(rst_n), .we(res_we), .line(host_line), .slot(host_slot),
    .wdata(host_wdata), .lk_line(win), .commit(commit), .rd_word(res_rd), .lk_res(win_res)
  );

  tmt_prio #(.LINES(LINES), .LW(LW)) u_prio (
    .clk(clk), .rst_n(rst_n), .vec(match_vec), .any(any), .idx(win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
      hit_valid  <= 1'b0;
      hit        <= 1'b0;
      hit_index  <= '0;
      hit_result <= '0;
    end else begin
      if (host_re) host_rdata <= host_sel_res ? res_rd : arr_rd;
      hit_valid <= lk_valid;
      if (lk_valid) begin
        hit        <= any;
        hit_index  <= any ? win : '0;
        hit_result <= any ? win_res : '0;
      end
    end
  end

  // R8: each lookup is answered exactly one cycle later
  a_r8_answer: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> hit_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !hit_valid);

endmodule

// File: tb/tmt_table_test.sv
`timescale 1ns/1ps
module tmt_table_test;
  localparam int KW = 208;
  localparam int RW = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic host_we = 0, host_re = 0, host_sel_res = 0;
  logic [2:0] host_line = 0;
  logic [3:0] host_slot = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic lk_valid = 0;
  logic [KW-1:0] lk_key = '0;
  logic hit_valid, hit;
  logic [2:0] hit_index;
  logic [RW-1:0] hit_result;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmt_table uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_sel_res(host_sel_res), .host_line(host_line), .host_slot(host_slot),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .lk_valid(lk_valid),
    .lk_key(lk_key), .hit_valid(hit_valid), .hit(hit), .hit_index(hit_index),
    .hit_result(hit_result)
  );

  typedef struct {
    bit          h;
    int          idx;
    logic [RW-1:0] res;
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [KW-1:0] mk(input logic [15:0] top, input logic [31:0] w0);
    return {top, 160'h0, w0};
  endfunction

  function automatic logic [RW-1:0] rs(input logic [31:0] w3, input logic [31:0] w2,
                                       input logic [31:0] w1, input logic [31:0] w0);
    return {w3, w2, w1, w0};
  endfunction

  task automatic hw(input bit sel, input int line, input int slot, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_sel_res = sel; host_line = 3'(line); host_slot = 4'(slot); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input bit sel, input int line, input int slot, input logic [31:0] exp,
                    input string tag);
    @(negedge clk);
    host_re = 1; host_sel_res = sel; host_line = 3'(line); host_slot = 4'(slot);
    @(posedge clk); #1;
    n_run++;
    if (host_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read line %0d slot %0d: got %h expected %h", tag, line, slot, host_rdata, exp);
    end
    @(negedge clk);
    host_re = 0;
  endtask

  task automatic look(input logic [KW-1:0] k, input bit h, input int idx,
                      input logic [RW-1:0] res, input string tag);
    exp_t e;
    e.h = h; e.idx = idx; e.res = res; e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    lk_valid = 1; lk_key = k;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic prog_km(input int line, input logic [KW-1:0] k, input logic [KW-1:0] m);
    for (int i = 0; i < 6; i++) begin
      hw(0, line, 2*i, k[32*i +: 32]);
      hw(0, line, 2*i+1, m[32*i +: 32]);
    end
    hw(0, line, 12, {m[207:192], k[207:192]});
  endtask

  // monitor: pops the scoreboard as answers appear (R8)
  always @(posedge clk) begin
    #1;
    if (rst_n && hit_valid) begin
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R8 answer without lookup: got hit_valid %b expected 0", hit_valid);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (hit !== e.h || (e.h && (int'(hit_index) != e.idx)) || hit_result !== e.res) begin
          n_fail++;
          $display("FAIL %s lookup: got hit %b idx %0d res %h expected hit %b idx %0d res %h",
                   e.tag, hit, hit_index, hit_result, e.h, e.idx, e.res);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [RW-1:0] RES_A = {32'hA0000003, 32'hA0000002, 32'hA0000001, 32'hA0000000};
  localparam logic [RW-1:0] RES_B = {32'hB0000003, 32'hB0000002, 32'hB0000001, 32'hB0000000};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9: reset state
    rd(0, 0, 0, 32'h0, "R9");
    rd(0, 0, 13, 32'h1, "R9");
    look(mk(16'h5300, 32'h11112222), 0, 0, '0, "R9");

    // line 2: full word 0 cared, top byte cared (section 5, port 3)
    prog_km(2, mk(16'h5300, 32'h11112222), mk(16'hFF00, 32'hFFFFFFFF));
    look(mk(16'h5300, 32'h11112222), 0, 0, '0, "R5");   // not yet committed
    for (int w = 0; w < 4; w++) hw(1, 2, w, 32'hA0000000 + w);
    look(mk(16'h5300, 32'h11112222), 1, 2, RES_A, "R5");

    // line 5: upper half of word 0 and the port field cared, section wildcard
    prog_km(5, mk(16'h0300, 32'h11112222), mk(16'h0F00, 32'hFFFF0000));
    for (int w = 0; w < 4; w++) hw(1, 5, w, 32'hB0000000 + w);
    look(mk(16'h5300, 32'h11112222), 1, 2, RES_A, "R7");
    look(mk(16'h5300, 32'h1111FFFF), 1, 5, RES_B, "R3");
    look(mk(16'h5300, 32'h22222222), 0, 0, '0, "R3");
    look(mk(16'h9300, 32'h1111ABCD), 1, 5, RES_B, "R10");
    look(mk(16'h9400, 32'h1111ABCD), 0, 0, '0, "R10");

    // readback of the interleaved and packed slots
    rd(0, 2, 0, 32'h11112222, "R1");
    rd(0, 2, 1, 32'hFFFFFFFF, "R1");
    rd(0, 5, 1, 32'hFFFF0000, "R1");
    rd(0, 2, 12, 32'hFF005300, "R2");
    rd(0, 5, 12, 32'h0F000300, "R2");
    rd(0, 2, 13, 32'h0, "R4");

    // R6: staged word hidden until the commit, then merged sparsely
    hw(1, 5, 0, 32'hC0000000);
    look(mk(16'h9300, 32'h11110000), 1, 5, RES_B, "R6");
    rd(1, 5, 0, 32'hB0000000, "R6");
    hw(1, 5, 3, 32'hC0000003);
    look(mk(16'h9300, 32'h11110000), 1, 5,
         rs(32'hC0000003, 32'hB0000002, 32'hB0000001, 32'hC0000000), "R6");
    rd(1, 5, 0, 32'hC0000000, "R6");

    // R4: invalidate line 2, contents kept; a zero write is ignored
    hw(0, 2, 13, 32'h1);
    look(mk(16'h5300, 32'h11112222), 1, 5,
         rs(32'hC0000003, 32'hB0000002, 32'hB0000001, 32'hC0000000), "R4");
    rd(0, 2, 13, 32'h1, "R4");
    rd(0, 2, 0, 32'h11112222, "R4");
    rd(1, 2, 1, 32'hA0000001, "R4");
    hw(0, 5, 13, 32'h0);
    rd(0, 5, 13, 32'h0, "R4");

    // R5/R6: last word alone recommits line 2
    hw(1, 2, 3, 32'hD0000003);
    look(mk(16'h5300, 32'h11112222), 1, 2,
         rs(32'hD0000003, 32'hA0000002, 32'hA0000001, 32'hA0000000), "R5");

    // line 0: all-don't-care line, lowest index wins everywhere
    hw(1, 0, 3, 32'hE0000003);
    look(mk(16'h0000, 32'h22220000), 1, 0, rs(32'hE0000003, 0, 0, 0), "R3");
    look(mk(16'h5300, 32'h11112222), 1, 0, rs(32'hE0000003, 0, 0, 0), "R7");

    repeat (4) @(negedge clk);
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R8 unanswered lookups: got %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule